// File: doc/BRIEF.md
# Delay-Line Edge Parity Extractor

This block turns a set of captured delay-line snapshots into one raw random bit per sample. Several tapped delay lines, one per ring-oscillator stage, are frozen on the same clock edge; the block receives all of them at once together with a strobe that marks the sample as meaningful. It folds every line into a single vector with a bit-wise exclusive-or. It then looks for the lowest-indexed place where two neighbouring bits of that vector differ. The parity of that place becomes the output bit.

Only the first transition counts. A second transition, which appears when the oscillator edge runs out of one line and into the next, has no influence. Neither have isolated flipped bits past the first transition, such as metastability bubbles. A compile-time down-sampling factor can widen each bin so that several fine taps count as one position before the parity is taken. When the folded vector has no transition at all, the block raises a no-edge flag instead of a valid bit.

Top module: `edge_parity_extractor`

## Requirements
- R1: The snapshot bus carries N_LINES lines of LINE_W bits each, with line i in bits [i*LINE_W +: LINE_W] (defaults 3 and 36). The lines are folded by bit-wise XOR into one LINE_W-bit vector M before any decoding, so lines that cancel in the XOR have no effect on the result.
- R2: The edge position E is 1 plus the lowest index j (0 ≤ j ≤ LINE_W-2) for which M[j] differs from M[j+1], giving 1 ≤ E ≤ LINE_W-1. E is the index of the first bit that differs from M[0].
- R3: Any transition above the first one does not change the output. This covers a second edge and bubble bits at higher indices.
- R4: With down-sampling factor DS_FACTOR = K (1 or 4), the bin index is floor(E / K). The output bit is 1 when the bin index is even and 0 when it is odd.
- R5: A strobed sample whose M has no transition (all zeros or all ones) sets no_edge_o to 1 and keeps raw_valid_o at 0 in the following cycle. raw_valid_o and no_edge_o are never high together.
- R6: A strobe sampled on a rising clock edge produces its result (raw_valid_o or no_edge_o) right after that edge, so the latency is one cycle. In a cycle that follows an edge with no strobe, both flags are 0.
- R7: raw_bit_o changes only together with a new valid result. Otherwise it keeps the last valid bit.
- R8: While rst_ni is low, and after its release until the first strobe, raw_bit_o, raw_valid_o and no_edge_o are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sampling clock, rising edge active |
| rst_ni | input | 1 | Asynchronous active-low reset |
| smp_valid_i | input | 1 | Marks lines_i as a snapshot to decode in this cycle |
| lines_i | input | N_LINES*LINE_W | All delay-line snapshots, line i in bits [i*LINE_W +: LINE_W] |
| raw_bit_o | output | 1 | Parity-derived raw bit of the last sample that had an edge |
| raw_valid_o | output | 1 | One-cycle pulse: raw_bit_o carries a new bit |
| no_edge_o | output | 1 | One-cycle pulse: the last strobed sample held no transition |

## Verification
The checker relies on the strobe being a level that is sampled cleanly on the rising edge and held at 0 throughout reset. It also relies on the snapshot bus being fully driven whenever the strobe is high, so that every strobed cycle produces exactly one of the two result flags. The bench changes inputs only on the falling edge and keeps the strobe at 0 during reset. It fills the bus with defined bits on every sample: random words, and hand-built clean edges, double edges and bubbled vectors. Idle cycles are mixed in to exercise the hold and the flag clearing.

// File: rtl/edge_pkg.sv
package edge_pkg;

    // Registered result of one decoded sample
    typedef struct packed {
        logic rnd;      // raw random bit
        logic valid;    // new bit this cycle
        logic no_edge;  // strobed sample had no transition
    } edge_result_t;

endpackage

// File: rtl/edge_line_merge.sv
module edge_line_merge #(
    parameter int N_LINES = 3,
    parameter int LINE_W  = 36
) (
    input  logic [N_LINES*LINE_W-1:0] lines_i,
    output logic [LINE_W-1:0]         merged_o
);

    // Column j gathers tap j of every line
    logic [N_LINES-1:0] column [LINE_W];

    for (genvar j = 0; j < LINE_W; j++) begin : g_tap
        for (genvar i = 0; i < N_LINES; i++) begin : g_line
            assign column[j][i] = lines_i[i*LINE_W + j];
        end
        assign merged_o[j] = ^column[j];
    end

endmodule

// File: rtl/edge_first_find.sv
module edge_first_find #(
    parameter int LINE_W = 36,
    localparam int POS_W = $clog2(LINE_W)
) (
    input  logic [LINE_W-1:0] merged_i,
    output logic              found_o,
    output logic [POS_W-1:0]  pos_o
);

    logic [LINE_W-2:0] trans;

    // Adjacent-pair difference marks every boundary between runs
    assign trans = merged_i[LINE_W-1:1] ^ merged_i[LINE_W-2:0];

    // Scan downwards so the lowest boundary is the one kept
    always_comb begin
        found_o = 1'b0;
        pos_o   = '0;
        for (int j = LINE_W - 2; j >= 0; j--) begin
            if (trans[j]) begin
                found_o = 1'b1;
                pos_o   = POS_W'(j + 1);
            end
        end
    end

endmodule

// File: rtl/edge_bin_parity.sv
module edge_bin_parity #(
    parameter int LINE_W    = 36,
    parameter int DS_FACTOR = 1,
    localparam int POS_W    = $clog2(LINE_W),
    localparam int DS_SHIFT = $clog2(DS_FACTOR)
) (
    input  logic [POS_W-1:0] pos_i,
    output logic             bit_o
);

    logic [POS_W-1:0] sel_mask;

    // The parity bit of the coarse bin sits DS_SHIFT places up
    if (DS_FACTOR == 1) begin : g_fine
        assign sel_mask = POS_W'(1);
    end else begin : g_coarse
        assign sel_mask = POS_W'(1) << DS_SHIFT;
    end

    // Even bin gives 1, odd bin gives 0
    assign bit_o = ~(^(pos_i & sel_mask));

endmodule

// File: rtl/edge_parity_extractor.sv
module edge_parity_extractor
    import edge_pkg::*;
#(
    parameter int N_LINES   = 3,
    parameter int LINE_W    = 36,
    parameter int DS_FACTOR = 1,
    localparam int POS_W    = $clog2(LINE_W)
) (
    input  logic                      clk_i,
    input  logic                      rst_ni,
    input  logic                      smp_valid_i,
    input  logic [N_LINES*LINE_W-1:0] lines_i,
    output logic                      raw_bit_o,
    output logic                      raw_valid_o,
    output logic                      no_edge_o
);

    logic [LINE_W-1:0] merged;
    logic              found;
    logic [POS_W-1:0]  pos;
    logic              bin_bit;
    edge_result_t      res_d, res_q;

    edge_line_merge #(
        .N_LINES(N_LINES),
        .LINE_W (LINE_W)
    ) u_merge (
        .lines_i (lines_i),
        .merged_o(merged)
    );

    edge_first_find #(
        .LINE_W(LINE_W)
    ) u_find (
        .merged_i(merged),
        .found_o (found),
        .pos_o   (pos)
    );

    edge_bin_parity #(
        .LINE_W   (LINE_W),
        .DS_FACTOR(DS_FACTOR)
    ) u_bin (
        .pos_i(pos),
        .bit_o(bin_bit)
    );

    always_comb begin
        res_d         = res_q;
        res_d.valid   = 1'b0;
        res_d.no_edge = 1'b0;
        if (smp_valid_i) begin
            if (found) begin
                res_d.valid = 1'b1;
                res_d.rnd   = bin_bit;
            end else begin
                res_d.no_edge = 1'b1;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            res_q <= '0;
        end else begin
            res_q <= res_d;
        end
    end

    assign raw_bit_o   = res_q.rnd;
    assign raw_valid_o = res_q.valid;
    assign no_edge_o   = res_q.no_edge;

endmodule

// File: rtl/edge_parity_extractor_chk.sv
module edge_parity_extractor_chk (
    input logic clk_i,
    input logic rst_ni,
    input logic smp_valid_i,
    input logic raw_bit_o,
    input logic raw_valid_o,
    input logic no_edge_o
);

    // R5
    flags_exclusive_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(raw_valid_o && no_edge_o));

    // R6
    valid_needs_strobe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        raw_valid_o |-> $past(smp_valid_i));

    // R5
    no_edge_needs_strobe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        no_edge_o |-> $past(smp_valid_i));

    // R6
    strobe_gives_result_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        smp_valid_i |=> (raw_valid_o || no_edge_o));

    // R7
    bit_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !raw_valid_o |-> $stable(raw_bit_o));

    // R8
    always @(posedge clk_i) begin
        if (!rst_ni) begin
            reset_quiet_chk: assert (!raw_valid_o && !no_edge_o && !raw_bit_o);
        end
    end

endmodule

bind edge_parity_extractor edge_parity_extractor_chk u_chk (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .smp_valid_i(smp_valid_i),
    .raw_bit_o  (raw_bit_o),
    .raw_valid_o(raw_valid_o),
    .no_edge_o  (no_edge_o)
);

// File: tb/tb_edge_parity_extractor.sv
`timescale 1ns/1ps
module tb_edge_parity_extractor;

    localparam int NL = 3;
    localparam int LW = 36;
    localparam int BW = NL * LW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          stb = 1'b0;
    logic [BW-1:0] lines = '0;
    logic          bit1, val1, ne1;
    logic          bit4, val4, ne4;

    int checks = 0;
    int errors = 0;
    logic hold1 = 1'b0;
    logic hold4 = 1'b0;

    always #4 clk = ~clk;

    edge_parity_extractor #(.N_LINES(NL), .LINE_W(LW), .DS_FACTOR(1)) dut (
        .clk_i(clk), .rst_ni(rst_n), .smp_valid_i(stb), .lines_i(lines),
        .raw_bit_o(bit1), .raw_valid_o(val1), .no_edge_o(ne1));

    edge_parity_extractor #(.N_LINES(NL), .LINE_W(LW), .DS_FACTOR(4)) dut_k4 (
        .clk_i(clk), .rst_ni(rst_n), .smp_valid_i(stb), .lines_i(lines),
        .raw_bit_o(bit4), .raw_valid_o(val4), .no_edge_o(ne4));

    task automatic check(input logic got, input logic exp, input string what);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %0b expected %0b", what, got, exp);
        end
    endtask

    // Edge position per R1/R2, 0 when none
    function automatic int edge_pos(input logic [BW-1:0] v);
        logic [LW-1:0] m = '0;
        for (int i = 0; i < NL; i++) m ^= v[i*LW +: LW];
        for (int j = 0; j < LW - 1; j++)
            if (m[j] != m[j+1]) return j + 1;
        return 0;
    endfunction

    // R4 bin parity
    function automatic logic bin_bit(input int e, input int k);
        return ((e / k) % 2) == 0;
    endfunction

    function automatic logic [LW-1:0] clean(input int e, input logic start);
        logic [LW-1:0] r;
        for (int j = 0; j < LW; j++) r[j] = (j < e) ? start : ~start;
        return r;
    endfunction

    // Apply one strobed sample and check result after one cycle (R6)
    task automatic apply(input logic [BW-1:0] v, input string tag);
        int e;
        e = edge_pos(v);
        lines = v;
        stb   = 1'b1;
        @(negedge clk);
        stb   = 1'b0;
        if (e == 0) begin
            check(val1, 1'b0, {tag, " R5 valid k1"});
            check(ne1,  1'b1, {tag, " R5 no_edge k1"});
            check(val4, 1'b0, {tag, " R5 valid k4"});
            check(ne4,  1'b1, {tag, " R5 no_edge k4"});
        end else begin
            hold1 = bin_bit(e, 1);
            hold4 = bin_bit(e, 4);
            check(val1, 1'b1, {tag, " R6 valid k1"});
            check(ne1,  1'b0, {tag, " R6 no_edge k1"});
            check(val4, 1'b1, {tag, " R6 valid k4"});
        end
        check(bit1, hold1, {tag, " R2 R4 bit k1"});
        check(bit4, hold4, {tag, " R4 bit k4"});
    endtask

    task automatic idle_check();
        lines = {$urandom, $urandom, $urandom, $urandom};
        @(negedge clk);
        check(val1 | ne1 | val4 | ne4, 1'b0, "R6 flags clear without strobe");
        check(bit1, hold1, "R7 bit held k1");
        check(bit4, hold4, "R7 bit held k4");
    endtask

    initial begin
        #(8 * 150000);
        errors++;
        $display("FAIL watchdog expired");
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [LW-1:0] a;
        logic [LW-1:0] b;
        void'($urandom(32'h5eed_1234));
        repeat (3) @(negedge clk);
        check(val1 | ne1 | bit1 | val4 | ne4 | bit4, 1'b0, "R8 outputs in reset");
        rst_n = 1'b1;
        @(negedge clk);
        check(val1 | ne1 | bit1, 1'b0, "R8 outputs after release");

        // R5: no transition, zeros and ones
        apply('0, "all-zero");
        apply({BW{1'b1}} ^ {{(2*LW){1'b0}}, {LW{1'b1}}} ^ {{LW{1'b0}}, {LW{1'b1}}, {LW{1'b0}}}, "all-one merged");
        idle_check();

        // R2/R4: clean edges at every position, both polarities
        for (int e = 1; e < LW; e++) begin
            apply({{(2*LW){1'b0}}, clean(e, e[0])}, "R2 clean sweep");
        end

        // R1: two identical lines cancel
        a = {$urandom, $urandom};
        apply({a, a, clean(7, 1'b1)}, "R1 cancel");
        a = clean(12, 1'b0);
        b = clean(20, 1'b0);
        apply({{LW{1'b0}}, b, a}, "R1 xor two edges");

        // R3: double edge and bubbles past the first edge
        a = clean(10, 1'b1);
        a[35:30] = '1;
        apply({{(2*LW){1'b0}}, a}, "R3 double edge");
        a = clean(5, 1'b0);
        a[9] = 1'b0; a[17] = 1'b0; a[30] = 1'b0;
        apply({{(2*LW){1'b0}}, a}, "R3 bubbles");
        idle_check();

        // R4: bin boundaries for K=4
        apply({{(2*LW){1'b0}}, clean(3, 1'b1)}, "R4 bin0 end");
        apply({{(2*LW){1'b0}}, clean(4, 1'b1)}, "R4 bin1 start");
        apply({{(2*LW){1'b0}}, clean(8, 1'b1)}, "R4 bin2 start");
        apply({{(2*LW){1'b0}}, clean(LW - 1, 1'b0)}, "R4 last tap");

        // Random mix with edge-shaped samples and idle gaps
        for (int n = 0; n < 400; n++) begin
            if ($urandom_range(0, 2) == 0) begin
                apply({$urandom, $urandom, $urandom, $urandom}, "R2 random");
            end else begin
                a = clean($urandom_range(0, LW), 1'($urandom));
                if ($urandom_range(0, 1) == 1) a[$urandom_range(0, LW - 1)] ^= 1'b1;
                b = {$urandom, $urandom};
                apply({b, b, a}, "R3 random shaped");
            end
            if ($urandom_range(0, 3) == 0) idle_check();
        end

        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule